// File: doc/BRIEF.md
# ECC Error Interrupt Aggregator

This block gathers error event pulses from up to 256 ECC-protected endpoints and turns them into two level interrupts. One interrupt covers correctable events, where an endpoint has fixed a single-bit error. The other covers non-correctable events: double-bit detections, parity-check failures, redundancy-check failures and timeouts. Each endpoint owns one bit in each class. That bit sits at word `w`, bit `j` of a bank, where endpoint = 32*w + j.

Each class keeps a latched status bit and an enable bit for every endpoint. Software works through a plain register port: a write strobe, an address and write data, with read data returned combinationally for the current address. Software turns endpoints on through a write-one-to-set enable bank and off through a write-one-to-clear enable bank. When an interrupt fires, it reads the status bank to find the failing endpoint and clears that bit by writing one to it. It then writes the class's end-of-interrupt register, which re-arms the output.

Top module: `ecc_irq_aggregator`

## Requirements
- R1: After synchronous reset, every enable bit, every status bit and both interrupt outputs are 0, and every status word reads 0.
- R2: The register address is {class, bank[1:0], word[2:0]}. Class 0 is correctable and class 1 is non-correctable. Bank 0 is enable-set, bank 1 is enable-clear, bank 2 is status and bank 3 is end-of-interrupt. Banks 0 and 1 both read back the enable word, bank 2 reads the status word, and bank 3 reads 0.
- R3: Writing a 1 to a bit of an enable-set word enables that endpoint. Bits written 0 leave their enables unchanged.
- R4: Writing a 1 to a bit of an enable-clear word disables that endpoint. Bits written 0 leave their enables unchanged.
- R5: An event pulse sampled at a clock edge sets the endpoint's status bit, whether or not the endpoint is enabled. The bit is readable right after that edge.
- R6: Correctable status is set by `sec_evt`. Non-correctable status is set by any of `ded_evt`, `par_evt`, `rdn_evt` and `tmo_evt`.
- R7: Writing a 1 to a status bit clears it, and bits written 0 are untouched. When an event and a clear hit the same bit at the same edge, the bit stays set.
- R8: A class's interrupt output is a register that holds the OR over all endpoints of (status AND enable). It follows any change of status or enable one clock edge later.
- R9: A write to a class's bank 3 with `reg_wdata[0]`=1 (any word index) drives that class's interrupt low for exactly one cycle. The interrupt returns on the following edge if an enabled status bit is still set. A bank 3 write with `reg_wdata[0]`=0 has no effect.
- R10: The two classes are independent. An end-of-interrupt write, an enable change or a status clear in one class leaves the other class's state and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_evt | input | 256 | Correctable event pulses, one per endpoint |
| ded_evt | input | 256 | Double-bit detection pulses |
| par_evt | input | 256 | Parity-check failure pulses |
| rdn_evt | input | 256 | Redundancy-check failure pulses |
| tmo_evt | input | 256 | Timeout pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address {class, bank, word} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| sec_irq | output | 1 | Correctable interrupt (level) |
| ded_irq | output | 1 | Non-correctable interrupt (level) |

## Verification
Status and enable writes, and event pulses, become visible on `reg_rdata` right after the edge that samples them. The bench therefore reads them back at the falling edge that follows. The interrupt outputs trail the state by one more edge. The bench checks that the interrupt still holds its old value at the first falling edge after a change and holds its new value at the next one. After an end-of-interrupt write the output is checked low at the first falling edge and high again at the second, while the other class's output is checked unchanged in the same cycles.

// File: rtl/ecc_agg_pkg.sv
package ecc_agg_pkg;

    typedef enum logic [1:0] {
        BANK_EN_SET = 2'd0,
        BANK_EN_CLR = 2'd1,
        BANK_STATUS = 2'd2,
        BANK_EOI    = 2'd3
    } bank_e;

    typedef enum logic {
        CLS_CORR   = 1'b0,
        CLS_UNCORR = 1'b1
    } cls_e;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic sts_clr;
        logic eoi;
    } wr_cmd_t;

    function automatic wr_cmd_t bank_cmd(input logic wr, input bank_e bank);
        wr_cmd_t c;
        c.en_set  = wr && (bank == BANK_EN_SET);
        c.en_clr  = wr && (bank == BANK_EN_CLR);
        c.sts_clr = wr && (bank == BANK_STATUS);
        c.eoi     = wr && (bank == BANK_EOI);
        return c;
    endfunction

endpackage

// File: rtl/ecc_agg_regdec.sv
module ecc_agg_regdec
    import ecc_agg_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             reg_wr,
    input  logic [IDX_W+2:0] reg_addr,
    output wr_cmd_t          cmd_corr,
    output wr_cmd_t          cmd_uncorr,
    output cls_e             cls,
    output bank_e            bank,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        cls        = cls_e'(reg_addr[IDX_W+2]);
        bank       = bank_e'(reg_addr[IDX_W+1:IDX_W]);
        idx        = reg_addr[IDX_W-1:0];
        cmd_corr   = bank_cmd(reg_wr && (cls == CLS_CORR), bank);
        cmd_uncorr = bank_cmd(reg_wr && (cls == CLS_UNCORR), bank);
    end
endmodule

// File: rtl/ecc_agg_class.sv
module ecc_agg_class
    import ecc_agg_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 3,
    localparam int N_EP     = NUM_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EP-1:0]   evt,
    input  wr_cmd_t           cmd,
    input  bank_e             bank,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_data,
    output logic              eoi_fire,
    output logic              pend_any,
    output logic              irq
);
    logic [WORD_W-1:0]    en_q  [NUM_WORDS];
    logic [WORD_W-1:0]    sts_q [NUM_WORDS];
    logic [NUM_WORDS-1:0] word_hit;
    logic                 irq_q;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic              sel;
        logic [WORD_W-1:0] clr_mask;

        assign sel      = (idx == IDX_W'(w));
        assign clr_mask = (cmd.sts_clr && sel) ? wdata : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[w] <= '0;
            end else if (cmd.en_set && sel) begin
                en_q[w] <= en_q[w] | wdata;
            end else if (cmd.en_clr && sel) begin
                en_q[w] <= en_q[w] & ~wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sts_q[w] <= '0;
            end else begin
                sts_q[w] <= (sts_q[w] & ~clr_mask) | evt[w*WORD_W +: WORD_W];
            end
        end

        assign word_hit[w] = |(en_q[w] & sts_q[w]);
    end

    assign pend_any = |word_hit;
    assign eoi_fire = cmd.eoi && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= pend_any && !eoi_fire;
    end

    assign irq = irq_q;

    always_comb begin
        unique case (bank)
            BANK_EN_SET,
            BANK_EN_CLR: rd_data = en_q[idx];
            BANK_STATUS: rd_data = sts_q[idx];
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ecc_irq_aggregator.sv
module ecc_irq_aggregator
    import ecc_agg_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int WORD_W    = 32,
    localparam int N_EP     = NUM_WORDS * WORD_W,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int ADDR_W   = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EP-1:0]   sec_evt,
    input  logic [N_EP-1:0]   ded_evt,
    input  logic [N_EP-1:0]   par_evt,
    input  logic [N_EP-1:0]   rdn_evt,
    input  logic [N_EP-1:0]   tmo_evt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              sec_irq,
    output logic              ded_irq
);
    wr_cmd_t           cmd_corr, cmd_uncorr;
    cls_e              rd_cls;
    bank_e             rd_bank;
    logic [IDX_W-1:0]  rd_idx;
    logic [WORD_W-1:0] rdata_corr, rdata_uncorr;
    logic [N_EP-1:0]   uncorr_evt;
    logic              eoi_corr, eoi_uncorr;
    logic              pend_corr, pend_uncorr;

    ecc_agg_regdec #(.IDX_W(IDX_W)) u_dec (
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .cmd_corr   (cmd_corr),
        .cmd_uncorr (cmd_uncorr),
        .cls        (rd_cls),
        .bank       (rd_bank),
        .idx        (rd_idx)
    );

    assign uncorr_evt = ded_evt | par_evt | rdn_evt | tmo_evt;

    ecc_agg_class #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_corr (
        .clk      (clk),
        .rst      (rst),
        .evt      (sec_evt),
        .cmd      (cmd_corr),
        .bank     (rd_bank),
        .idx      (rd_idx),
        .wdata    (reg_wdata),
        .rd_data  (rdata_corr),
        .eoi_fire (eoi_corr),
        .pend_any (pend_corr),
        .irq      (sec_irq)
    );

    ecc_agg_class #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_uncorr (
        .clk      (clk),
        .rst      (rst),
        .evt      (uncorr_evt),
        .cmd      (cmd_uncorr),
        .bank     (rd_bank),
        .idx      (rd_idx),
        .wdata    (reg_wdata),
        .rd_data  (rdata_uncorr),
        .eoi_fire (eoi_uncorr),
        .pend_any (pend_uncorr),
        .irq      (ded_irq)
    );

    assign reg_rdata = (rd_cls == CLS_UNCORR) ? rdata_uncorr : rdata_corr;
endmodule

// File: rtl/ecc_agg_checker.sv
module ecc_agg_checker (
    input logic clk,
    input logic rst,
    input logic sec_irq,
    input logic ded_irq,
    input logic sec_pend,
    input logic ded_pend,
    input logic sec_eoi,
    input logic ded_eoi
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!sec_irq && !ded_irq));

    assert_sec_follows_pend_R8: assert property (@(posedge clk) disable iff (rst)
        (sec_pend && !sec_eoi) |=> sec_irq);

    assert_sec_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !sec_pend |=> !sec_irq);

    assert_ded_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !ded_pend |=> !ded_irq);

    assert_sec_eoi_low_R9: assert property (@(posedge clk) disable iff (rst)
        sec_eoi |=> !sec_irq);

    assert_ded_eoi_low_R9: assert property (@(posedge clk) disable iff (rst)
        ded_eoi |=> !ded_irq);

    assert_ded_isolated_R10: assert property (@(posedge clk) disable iff (rst)
        (sec_eoi && !ded_eoi && ded_pend) |=> ded_irq);

    assert_sec_isolated_R10: assert property (@(posedge clk) disable iff (rst)
        (ded_eoi && !sec_eoi && sec_pend) |=> sec_irq);
endmodule

bind ecc_irq_aggregator ecc_agg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .sec_irq  (sec_irq),
    .ded_irq  (ded_irq),
    .sec_pend (pend_corr),
    .ded_pend (pend_uncorr),
    .sec_eoi  (eoi_corr),
    .ded_eoi  (eoi_uncorr)
);

// File: tb/tb_ecc_irq_aggregator.sv
`timescale 1ns/1ps
module tb_ecc_irq_aggregator;
    localparam int NEP = 256;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NEP-1:0] sec_evt = '0, ded_evt = '0, par_evt = '0, rdn_evt = '0, tmo_evt = '0;
    logic           reg_wr = 1'b0;
    logic [5:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           sec_irq, ded_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ecc_irq_aggregator dut (
        .clk(clk), .rst(rst),
        .sec_evt(sec_evt), .ded_evt(ded_evt), .par_evt(par_evt),
        .rdn_evt(rdn_evt), .tmo_evt(tmo_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sec_irq(sec_irq), .ded_irq(ded_irq)
    );

    function automatic logic [5:0] adr(input int cls, input int bank, input int w);
        return {cls[0], bank[1:0], w[2:0]};
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    function automatic logic irq_of(input int cls);
        return cls == 0 ? sec_irq : ded_irq;
    endfunction

    task automatic pulse(input int cls, input int src, input int ep);
        if (cls == 0) sec_evt[ep] = 1'b1;
        else case (src)
            0: ded_evt[ep] = 1'b1;
            1: par_evt[ep] = 1'b1;
            2: rdn_evt[ep] = 1'b1;
            default: tmo_evt[ep] = 1'b1;
        endcase
        @(negedge clk);
        sec_evt = '0; ded_evt = '0; par_evt = '0; rdn_evt = '0; tmo_evt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk({31'd0, sec_irq}, 0, "R1 sec_irq");
        chk({31'd0, ded_irq}, 0, "R1 ded_irq");
        for (int c = 0; c < 2; c++)
            for (int w = 0; w < 8; w++) begin
                rd(adr(c, 2, w), d); chk(d, 0, "R1 status");
                rd(adr(c, 0, w), d); chk(d, 0, "R1 enable");
            end

        // Sweep every endpoint of both classes (R2..R8)
        for (int c = 0; c < 2; c++)
            for (int ep = 0; ep < NEP; ep++) begin
                automatic int w = ep / 32;
                automatic logic [31:0] bit_m = 32'd1 << (ep % 32);
                pulse(c, ep % 4, ep);
                rd(adr(c, 2, w), d); chk(d, bit_m, "R5 R6 status set on event");
                rd(adr(1 - c, 2, w), d); chk(d, 0, "R10 other class status");
                @(negedge clk);
                chk({31'd0, irq_of(c)}, 0, "R8 disabled endpoint no irq");
                wr(adr(c, 0, w), bit_m);
                rd(adr(c, 1, w), d); chk(d, bit_m, "R3 R2 enable readback");
                chk({31'd0, irq_of(c)}, 0, "R8 irq one edge late");
                @(negedge clk);
                chk({31'd0, irq_of(c)}, 1, "R8 irq asserted");
                chk({31'd0, irq_of(1 - c)}, 0, "R10 other irq idle");
                wr(adr(c, 2, w), bit_m);
                rd(adr(c, 2, w), d); chk(d, 0, "R7 status cleared");
                @(negedge clk);
                chk({31'd0, irq_of(c)}, 0, "R8 irq dropped");
                wr(adr(c, 1, w), bit_m);
                rd(adr(c, 0, w), d); chk(d, 0, "R4 enable cleared");
            end

        // R3/R4 zero bits leave enables alone
        wr(adr(0, 0, 3), 32'hA5A5_0F0F);
        wr(adr(0, 0, 3), 32'h0);
        rd(adr(0, 0, 3), d); chk(d, 32'hA5A5_0F0F, "R3 zero write no effect");
        wr(adr(0, 1, 3), 32'h0000_0F00);
        rd(adr(0, 0, 3), d); chk(d, 32'hA5A5_000F, "R4 partial clear");
        wr(adr(0, 1, 3), 32'h0);
        rd(adr(0, 0, 3), d); chk(d, 32'hA5A5_000F, "R4 zero write no effect");
        rd(adr(0, 3, 3), d); chk(d, 0, "R2 eoi bank reads 0");
        wr(adr(0, 1, 3), 32'hFFFF_FFFF);

        // R7 same-edge event and clear: event wins; zero bits untouched
        pulse(1, 0, 40); pulse(1, 1, 41);
        sec_evt = '0;
        ded_evt[40] = 1'b1;
        wr(adr(1, 2, 1), 32'h0000_0300);
        ded_evt = '0;
        rd(adr(1, 2, 1), d); chk(d, 32'h0000_0100, "R7 event beats clear");
        wr(adr(1, 2, 1), 32'h0);
        rd(adr(1, 2, 1), d); chk(d, 32'h0000_0100, "R7 zero clear no effect");

        // R9/R10 end of interrupt on both classes with pending bits
        pulse(0, 0, 200);
        wr(adr(1, 0, 1), 32'h0000_0100);
        wr(adr(0, 0, 6), 32'h0000_0100);
        @(negedge clk);
        chk({31'd0, sec_irq}, 1, "R9 sec irq before eoi");
        chk({31'd0, ded_irq}, 1, "R9 ded irq before eoi");
        wr(adr(0, 3, 5), 32'h0000_0000);
        chk({31'd0, sec_irq}, 1, "R9 eoi data 0 no effect");
        wr(adr(0, 3, 5), 32'h0000_0001);
        chk({31'd0, sec_irq}, 0, "R9 sec low after eoi");
        chk({31'd0, ded_irq}, 1, "R10 ded unaffected by sec eoi");
        @(negedge clk);
        chk({31'd0, sec_irq}, 1, "R9 sec reasserts");
        wr(adr(1, 3, 0), 32'h0000_0001);
        chk({31'd0, ded_irq}, 0, "R9 ded low after eoi");
        chk({31'd0, sec_irq}, 1, "R10 sec unaffected by ded eoi");
        @(negedge clk);
        chk({31'd0, ded_irq}, 1, "R9 ded reasserts");
        // clear then eoi: stays low
        wr(adr(0, 2, 6), 32'h0000_0100);
        wr(adr(0, 3, 0), 32'h0000_0001);
        @(negedge clk);
        chk({31'd0, sec_irq}, 0, "R9 no reassert when serviced");

        // R1 reset clears everything again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk({30'd0, sec_irq, ded_irq}, 0, "R1 irqs after reset");
        rd(adr(1, 2, 1), d); chk(d, 0, "R1 status after reset");
        rd(adr(1, 0, 1), d); chk(d, 0, "R1 enable after reset");

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule